// File: doc/BRIEF.md
# Dual-Port GPIO Register Bank

This block holds the control state for two byte-wide general-purpose I/O ports and turns it into pad controls. Each pin has four settings of its own: an output latch, a direction, a drive style (push-pull or open-drain) and a pull-up enable. A host reaches them over a simple byte bus with an address, a write strobe and a read strobe. A hard reset puts every register in its defined state.

On the pad side, each pin presents an output level, an output enable and a pull-up enable, and takes in an input level. Open-drain drive works through the output enable. The pad is pulled low to signal a zero, and the enable is released to signal a one. Pad inputs pass through a two-stage synchronizer before they reach the read path.

A reading of a port's data register returns a mix. Pins set as outputs give the latched bit, and pins set as inputs give the synchronized pad level. One chosen pin, set by the parameter `DUAL_PIN`, is also driven onto a second pad, and that pad mirrors the pin's output controls. The pin's input always comes from its own primary pad.

Top module: `gpio_bank`

## Requirements
- R1: After hard reset, every port reads back data latch FFh, direction 00h, drive style 00h and pull-up FFh. While reset is held, `rdata` is 00h, every `pad_oe` bit is 0 and every `pad_pu` bit is 1.
- R2: Register decode uses the low three address bits. Bit 2 selects the port (0 = pins 7..0, 1 = pins 15..8). Bits 1..0 select the register: 0 = data, 1 = direction, 2 = drive style, 3 = pull-up. A write stores `wdata` at the clock edge where `wr` is high. The direction, drive-style and pull-up registers read back the stored value.
- R3: A read strobe sampled at a clock edge loads `rdata`, which is valid after that edge. Without a read strobe, `rdata` holds its value. In a data-register read, each bit whose direction bit is 1 returns the latch, and each bit whose direction bit is 0 returns the synchronized pad input.
- R4: A data-register write always updates the latch, whatever the direction setting. The stored value appears in reads once the direction bit is set to 1.
- R5: For a pin with direction 1 and drive style 1 (push-pull), `pad_oe` is 1 and `pad_out` equals the latch bit.
- R6: For a pin with direction 1 and drive style 0 (open-drain), `pad_out` is 0 and `pad_oe` is the inverse of the latch bit.
- R7: For a pin with direction 0, `pad_oe` is 0.
- R8: Each `pad_pu` bit equals the pin's pull-up register bit.
- R9: `alt_out`, `alt_oe` and `alt_pu` always equal `pad_out`, `pad_oe` and `pad_pu` of pin `DUAL_PIN`. That pin's input is read only from `pad_in[DUAL_PIN]`.
- R10: A pad input change made before clock edge E1 is not seen by reads sampled at E1 or E2. Reads sampled at E3 or later return the new level.
- R11: An address with any bit above bit 2 set is out of range. A write to it changes no register. A read from it returns 00h.
- R12: When `rd` and `wr` target the same register in the same cycle, `rdata` returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| addr | input | ADDR_W | Register address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| pad_in | input | PIN_N | Pad input levels |
| pad_out | output | PIN_N | Pad output levels |
| pad_oe | output | PIN_N | Pad output enables |
| pad_pu | output | PIN_N | Pad pull-up enables |
| alt_out | output | 1 | Second pad output level for pin DUAL_PIN |
| alt_oe | output | 1 | Second pad output enable for pin DUAL_PIN |
| alt_pu | output | 1 | Second pad pull-up enable for pin DUAL_PIN |

## Verification
Pad controls are decoded directly from the stored registers. A corrupted direction, drive-style, latch or pull-up bit therefore shows on `pad_oe`, `pad_out` or `pad_pu` at the negative edge right after the write that should have set it. A fault in the read steering or the synchronizer shows only in `rdata`, one edge after a read strobe. Synchronizer depth errors show as a new pad level appearing at the wrong edge of the three-edge window. A decode error that lets an out-of-range write through stays hidden until a later read or a pad check exposes the changed register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_DIR   = 2'd1,
    REG_STYLE = 2'd2,
    REG_PULL  = 2'd3
  } reg_sel_e;

  // output enable: only outputs drive; open-drain drives only a zero
  function automatic logic pin_oe(logic dir, logic push_pull, logic latch);
    return dir & (push_pull | ~latch);
  endfunction

  // output level: open-drain always presents a low when enabled
  function automatic logic pin_level(logic push_pull, logic latch);
    return push_pull & latch;
  endfunction

  // read steering per bit
  function automatic logic read_bit(logic dir, logic latch, logic pin);
    return dir ? latch : pin;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] style_o,
  output logic [W-1:0] pull_o
);

  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] style_q;
  logic [W-1:0] pull_q;
  logic [W-1:0] data_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      dir_q   <= '0;
      style_q <= '0;
      pull_q  <= '1;
    end else if (wr_en) begin
      case (sel)
        REG_DATA:  latch_q <= wdata;
        REG_DIR:   dir_q   <= wdata;
        REG_STYLE: style_q <= wdata;
        default:   pull_q  <= wdata;
      endcase
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign data_view[i] = read_bit(dir_q[i], latch_q[i], pin_sync[i]);
    assign pad_oe[i]    = pin_oe(dir_q[i], style_q[i], latch_q[i]);
    assign pad_out[i]   = pin_level(style_q[i], latch_q[i]);
  end

  assign pad_pu = pull_q;

  always_comb begin
    case (sel)
      REG_DATA:  rd_val = data_view;
      REG_DIR:   rd_val = dir_q;
      REG_STYLE: rd_val = style_q;
      default:   rd_val = pull_q;
    endcase
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign style_o = style_q;
  assign pull_o  = pull_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int N_PORTS  = 2,
  parameter int ADDR_W   = 4,
  parameter int DUAL_PIN = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr,
  input  logic                        rd,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  input  logic [DATA_W*N_PORTS-1:0]   pad_in,
  output logic [DATA_W*N_PORTS-1:0]   pad_out,
  output logic [DATA_W*N_PORTS-1:0]   pad_oe,
  output logic [DATA_W*N_PORTS-1:0]   pad_pu,
  output logic                        alt_out,
  output logic                        alt_oe,
  output logic                        alt_pu
);

  localparam int PIN_N      = DATA_W * N_PORTS;
  localparam int PORT_SEL_W = $clog2(N_PORTS);
  localparam int BASE_W     = 2 + PORT_SEL_W;

  logic                  in_range;
  logic                  wr_hit;
  logic                  rd_hit;
  logic [PORT_SEL_W-1:0] port_idx;
  reg_sel_e              reg_sel;
  logic [PIN_N-1:0]      pin_sync;
  logic [PIN_N-1:0]      latch_all;
  logic [PIN_N-1:0]      dir_all;
  logic [PIN_N-1:0]      style_all;
  logic [PIN_N-1:0]      pull_all;
  logic [DATA_W-1:0]     port_rd [N_PORTS];
  logic [DATA_W-1:0]     rdata_q;

  assign in_range = (addr[ADDR_W-1:BASE_W] == '0);
  assign wr_hit   = wr & in_range;
  assign rd_hit   = rd & in_range;
  assign port_idx = addr[BASE_W-1:2];
  assign reg_sel  = reg_sel_e'(addr[1:0]);

  gpio_sync #(.W(PIN_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic port_wr;
    assign port_wr = wr_hit && (port_idx == PORT_SEL_W'(p));

    gpio_port #(.W(DATA_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (port_wr),
      .sel      (reg_sel),
      .wdata    (wdata),
      .pin_sync (pin_sync[p*DATA_W +: DATA_W]),
      .rd_val   (port_rd[p]),
      .pad_out  (pad_out[p*DATA_W +: DATA_W]),
      .pad_oe   (pad_oe[p*DATA_W +: DATA_W]),
      .pad_pu   (pad_pu[p*DATA_W +: DATA_W]),
      .latch_o  (latch_all[p*DATA_W +: DATA_W]),
      .dir_o    (dir_all[p*DATA_W +: DATA_W]),
      .style_o  (style_all[p*DATA_W +: DATA_W]),
      .pull_o   (pull_all[p*DATA_W +: DATA_W])
    );
  end

  // registered read port; sampled before any same-cycle write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rd_hit ? port_rd[port_idx] : '0;
    end
  end

  assign rdata = rdata_q;

  // second pad for the shared pin mirrors its output controls
  assign alt_out = pad_out[DUAL_PIN];
  assign alt_oe  = pad_oe[DUAL_PIN];
  assign alt_pu  = pad_pu[DUAL_PIN];

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int PIN_N    = 16,
  parameter int DATA_W   = 8,
  parameter int DUAL_PIN = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd,
  input logic              wr,
  input logic              in_range,
  input logic [DATA_W-1:0] rdata,
  input logic [PIN_N-1:0]  pad_out,
  input logic [PIN_N-1:0]  pad_oe,
  input logic [PIN_N-1:0]  pad_pu,
  input logic [PIN_N-1:0]  latch_all,
  input logic [PIN_N-1:0]  dir_all,
  input logic [PIN_N-1:0]  style_all,
  input logic [PIN_N-1:0]  pull_all,
  input logic              alt_out,
  input logic              alt_oe,
  input logic              alt_pu
);

  // R7
  oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_all) == '0);

  // R6
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~style_all & pad_out) == '0);

  // R5
  pp_always_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_all & style_all & ~pad_oe) == '0);

  // R9
  alt_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_out == pad_out[DUAL_PIN]) && (alt_oe == pad_oe[DUAL_PIN]) &&
    (alt_pu == pad_pu[DUAL_PIN]));

  // R11
  oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !in_range) |=> (rdata == '0));

  // R11
  oor_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !in_range) |=> ($stable(latch_all) && $stable(dir_all) &&
                           $stable(style_all) && $stable(pull_all)));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

endmodule

bind gpio_bank gpio_bank_chk #(
  .PIN_N    (PIN_N),
  .DATA_W   (DATA_W),
  .DUAL_PIN (DUAL_PIN)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd        (rd),
  .wr        (wr),
  .in_range  (in_range),
  .rdata     (rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_pu    (pad_pu),
  .latch_all (latch_all),
  .dir_all   (dir_all),
  .style_all (style_all),
  .pull_all  (pull_all),
  .alt_out   (alt_out),
  .alt_oe    (alt_oe),
  .alt_pu    (alt_pu)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;

  localparam int DUAL = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pad_in = 16'h0000;
  logic [15:0] pad_out, pad_oe, pad_pu;
  logic        alt_out, alt_oe, alt_pu;

  int errors = 0;
  int checks = 0;

  logic [7:0] m_data [2];
  logic [7:0] m_dir  [2];
  logic [7:0] m_sty  [2];
  logic [7:0] m_pu   [2];

  always #4 clk = ~clk;

  gpio_bank #(.DATA_W(8), .N_PORTS(2), .ADDR_W(4), .DUAL_PIN(DUAL)) i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .alt_out(alt_out), .alt_oe(alt_oe), .alt_pu(alt_pu)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected pad enables, computed pin by pin from the mode table
  function automatic logic [15:0] exp_oe();
    logic [15:0] v = '0;
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 8; b++)
        if (m_dir[p][b] == 1'b0)      v[p*8+b] = 1'b0;
        else if (m_sty[p][b] == 1'b1) v[p*8+b] = 1'b1;
        else                          v[p*8+b] = (m_data[p][b] == 1'b0);
    return v;
  endfunction

  function automatic logic [15:0] exp_out();
    logic [15:0] v = '0;
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 8; b++)
        v[p*8+b] = (m_sty[p][b] == 1'b1) ? m_data[p][b] : 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] exp_read(logic [3:0] a);
    int p;
    logic [7:0] pins;
    if (a[3]) return 8'h00;
    p = int'(a[2]);
    pins = pad_in[p*8 +: 8];
    case (a[1:0])
      2'd0: begin
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = m_dir[p][b] ? m_data[p][b] : pins[b];
        return r;
      end
      2'd1: return m_dir[p];
      2'd2: return m_sty[p];
      default: return m_pu[p];
    endcase
  endfunction

  task automatic model_write(logic [3:0] a, logic [7:0] v);
    int p;
    if (a[3]) return;
    p = int'(a[2]);
    case (a[1:0])
      2'd0: m_data[p] = v;
      2'd1: m_dir[p]  = v;
      2'd2: m_sty[p]  = v;
      default: m_pu[p] = v;
    endcase
  endtask

  task automatic check_pads(string tag);
    logic [15:0] eo, ev, ep;
    eo = exp_oe();
    ev = exp_out();
    ep = {m_pu[1], m_pu[0]};
    chk({tag, " oe"}, 32'(pad_oe), 32'(eo));
    chk({tag, " out"}, 32'(pad_out), 32'(ev));
    chk({tag, " R8 pu"}, 32'(pad_pu), 32'(ep));
    chk({tag, " R9 alt"}, {29'd0, alt_out, alt_oe, alt_pu},
        {29'd0, ev[DUAL], eo[DUAL], ep[DUAL]});
  endtask

  task automatic do_wr(logic [3:0] a, logic [7:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    model_write(a, v);
  endtask

  task automatic do_rd(logic [3:0] a, string tag);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rd = 1'b1;
    e = exp_read(a);
    @(negedge clk);
    rd = 1'b0;
    chk(tag, 32'(rdata), 32'(e));
  endtask

  task automatic set_pins(logic [15:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int p = 0; p < 2; p++) begin
      m_data[p] = 8'hFF; m_dir[p] = 8'h00; m_sty[p] = 8'h00; m_pu[p] = 8'hFF;
    end
    pad_in = 16'h3CA5;
    repeat (3) @(negedge clk);
    // R1 values during reset
    chk("R1 rdata in reset", 32'(rdata), 32'h00);
    chk("R1 oe in reset", 32'(pad_oe), 32'h0000);
    chk("R1 pu in reset", 32'(pad_pu), 32'hFFFF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R2 reset read-back of every register
    for (int a = 1; a < 8; a++)
      if (a != 4) do_rd(4'(a), "R1 R2 reset readback");
    do_rd(4'd0, "R3 input pins port0");
    do_rd(4'd4, "R3 input pins port1");
    check_pads("R1 R7 reset pads");

    // R4 latch reset FF seen when direction flips
    do_wr(4'd5, 8'hFF);
    do_rd(4'd4, "R4 R1 latch reset FF");
    check_pads("R6 od release");

    // R4 data written while input, seen after switching to output
    do_wr(4'd5, 8'h00);
    do_wr(4'd4, 8'h5A);
    do_rd(4'd4, "R4 input mode shows pins");
    do_wr(4'd5, 8'hF0);
    do_rd(4'd4, "R4 mixed steering");
    check_pads("R6 open-drain mix");

    // R5 push-pull
    do_wr(4'd6, 8'hCC);
    check_pads("R5 push-pull mix");
    do_wr(4'd2, 8'hFF);
    do_wr(4'd1, 8'h0F);
    do_wr(4'd0, 8'h36);
    check_pads("R5 R7 port0");
    do_wr(4'd3, 8'h81);
    do_wr(4'd7, 8'h00);
    check_pads("R8 pull change");

    // R10 synchronizer window on port0 input bits
    do_wr(4'd1, 8'h00);
    set_pins(16'h0000);
    @(negedge clk);
    pad_in = 16'h00FF; addr = 4'd0; rd = 1'b1;
    @(negedge clk);
    chk("R10 read at E1 old", 32'(rdata), 32'h00);
    @(negedge clk);
    chk("R10 read at E2 old", 32'(rdata), 32'h00);
    @(negedge clk);
    rd = 1'b0;
    chk("R10 read at E3 new", 32'(rdata), 32'hFF);

    // R9 shared pin input follows its primary pad (pin 11, port1 bit 3)
    do_wr(4'd5, 8'h00);
    set_pins(16'h0800);
    do_rd(4'd4, "R9 primary pad input high");
    set_pins(16'h0000);
    do_rd(4'd4, "R9 primary pad input low");

    // R12 simultaneous read and write
    @(negedge clk);
    addr = 4'd6; wdata = 8'h99; wr = 1'b1; rd = 1'b1;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk("R12 read returns old", 32'(rdata), 32'(m_sty[1]));
    model_write(4'd6, 8'h99);
    do_rd(4'd6, "R12 new value stored");

    // R11 out-of-range
    for (int a = 8; a < 16; a++) begin
      do_wr(4'(a), 8'(a * 29));
      do_rd(4'(a), "R11 oor read zero");
    end
    for (int a = 0; a < 8; a++) do_rd(4'(a), "R11 regs untouched");
    check_pads("R11 pads untouched");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: do_wr(4'($urandom % 16), 8'($urandom));
        1: do_rd(4'($urandom % 16), "R2 R3 random read");
        2: set_pins(16'($urandom));
        default: do_wr({1'b0, 1'($urandom), 2'd0}, 8'($urandom));
      endcase
      check_pads("R5 R6 R7 random pads");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule